// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is one counter field of a hardware register. Hardware moves the count with single-cycle increment and decrement strobes. Software can replace the count through a write-enable and write-data pair. Each direction takes its step from one of three sources, chosen by parameter: a step of one, a fixed constant, or an input port whose width is a parameter. A fixed step of zero turns that direction off. Configuring both directions that way is rejected when the design is elaborated.

Each direction can be given a saturation limit. Without one, the count wraps modulo two to the power of the width. A one-cycle overflow pulse and a one-cycle underflow pulse report when an update passes the upper or lower limit. Two level flags report when the count has reached a high mark or fallen to a low mark. A per-bit update mask protects chosen bits from counter updates. A precedence parameter decides whether software or hardware wins when both act in the same cycle. All outputs are registered.

Top module: `updown_count_field`

## Requirements
- R1: Synchronous active-high reset loads the count with RST_VAL, clears both pulses and sets each mark flag from RST_VAL.
- R2: A strobed increment adds its step and a strobed decrement subtracts its step. When both are strobed in one cycle the net change is increment step minus decrement step. With no strobe and no write the count holds.
- R3: With upper saturation on, a net result above the upper limit loads the limit. The limit is all ones when no value is given.
- R4: With lower saturation on, a net result below the lower limit loads the limit. The limit is zero when no value is given.
- R5: With saturation off in a direction, the count wraps modulo 2^WIDTH.
- R6: over_o pulses for one cycle, together with the new count, when the net result is above the upper limit (all ones if upper saturation is off). under_o does the same when the net result is below the lower limit (zero if lower saturation is off). A result that equals a limit raises no pulse.
- R7: hi_mark_o is 1 while the count is at least HI_MARK_VAL (all ones if that value is -1). lo_mark_o is 1 while the count is at most LO_MARK_VAL. A disabled mark reads 0.
- R8: On a counter update, bits whose upd_mask_i bit is 0 keep their old value. Bits whose mask bit is 1 take the new value.
- R9: wr_en_i loads wr_data_i. If a counter update arrives in the same cycle, HW_WINS=0 lets the write win with no pulse, and HW_WINS=1 applies the update and drops the write.
- R10: A direction whose step is a fixed zero is tied off. Its strobe changes nothing and does not count as a conflicting update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_pulse_i | input | 1 | Increment strobe |
| inc_amt_i | input | INC_AMT_W | Increment step (used only when the step source is the input port) |
| dec_pulse_i | input | 1 | Decrement strobe |
| dec_amt_i | input | DEC_AMT_W | Decrement step (used only when the step source is the input port) |
| upd_mask_i | input | WIDTH | Per-bit enable for counter updates |
| wr_en_i | input | 1 | Software write enable |
| wr_data_i | input | WIDTH | Software write data |
| count_o | output | WIDTH | Current count |
| hi_mark_o | output | 1 | Count at or above the high mark |
| lo_mark_o | output | 1 | Count at or below the low mark |
| over_o | output | 1 | Overflow pulse |
| under_o | output | 1 | Underflow pulse |

## Verification
The bench steps the count right onto each saturation limit and one step beyond it. A design with an off-by-one limit compare would pulse on an exact hit or would miss the clamp. It strobes both directions in the same cycle, and a design that applied only one strobe would end on the wrong value. It puts a write and an update in the same cycle under both precedence settings, where a reversed priority shows up as the wrong final count or a stray overflow pulse. It also applies a partial update mask and a tied-off direction, which a design ignoring the mask or still treating the dead strobe as an update would get wrong.

// File: rtl/updown_pkg.sv
package updown_pkg;

  // Where a direction takes its step from.
  typedef enum logic [1:0] {
    STEP_UNIT  = 2'd0,  // step of one
    STEP_FIXED = 2'd1,  // constant parameter, zero ties the direction off
    STEP_INPUT = 2'd2   // variable-width input port
  } step_src_e;

endpackage

// File: rtl/updown_step_sel.sv
module updown_step_sel #(
  parameter updown_pkg::step_src_e SRC = updown_pkg::STEP_UNIT,
  parameter int CONST_VAL = 1,
  parameter int STEP_W    = 1,
  parameter int WIDTH     = 8
) (
  input  logic              strobe_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              active_o,
  output logic [WIDTH-1:0]  amount_o
);

  generate
    case (SRC)
      updown_pkg::STEP_INPUT: begin : g_port
        assign active_o = strobe_i;
        assign amount_o = WIDTH'(step_i);
      end
      updown_pkg::STEP_FIXED: begin : g_fixed
        logic unused_step;
        assign unused_step = ^step_i;
        if (CONST_VAL == 0) begin : g_tied
          logic unused_strobe;
          assign unused_strobe = strobe_i;
          assign active_o = 1'b0;
          assign amount_o = '0;
        end else begin : g_live
          assign active_o = strobe_i;
          assign amount_o = WIDTH'(CONST_VAL);
        end
      end
      default: begin : g_unit
        logic unused_step;
        assign unused_step = ^step_i;
        assign active_o = strobe_i;
        assign amount_o = WIDTH'(1);
      end
    endcase
  endgenerate

endmodule

// File: rtl/updown_next_calc.sv
module updown_next_calc #(
  parameter int WIDTH  = 8,
  parameter int UPPER  = 255,
  parameter int LOWER  = 0,
  parameter bit SAT_UP = 1'b0,
  parameter bit SAT_DN = 1'b0
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             inc_act_i,
  input  logic [WIDTH-1:0] inc_amt_i,
  input  logic             dec_act_i,
  input  logic [WIDTH-1:0] dec_amt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             above_o,
  output logic             below_o
);

  // Two extra bits hold the sum of two full-scale values and a sign.
  localparam int EXT = WIDTH + 2;
  localparam logic signed [EXT-1:0] UP_S = EXT'(UPPER);
  localparam logic signed [EXT-1:0] LO_S = EXT'(LOWER);

  logic [WIDTH-1:0]        inc_v, dec_v;
  logic signed [EXT-1:0]   net;
  logic [WIDTH-1:0]        wrapped;

  assign inc_v   = inc_act_i ? inc_amt_i : '0;
  assign dec_v   = dec_act_i ? dec_amt_i : '0;
  assign net     = $signed({2'b00, cnt_i}) + $signed({2'b00, inc_v})
                 - $signed({2'b00, dec_v});
  assign wrapped = net[WIDTH-1:0];
  assign above_o = net > UP_S;
  assign below_o = net < LO_S;

  generate
    if (SAT_UP && SAT_DN) begin : g_sat_both
      assign result_o = above_o ? WIDTH'(UPPER) : below_o ? WIDTH'(LOWER) : wrapped;
    end else if (SAT_UP) begin : g_sat_up
      assign result_o = above_o ? WIDTH'(UPPER) : wrapped;
    end else if (SAT_DN) begin : g_sat_dn
      assign result_o = below_o ? WIDTH'(LOWER) : wrapped;
    end else begin : g_wrap
      assign result_o = wrapped;
    end
  endgenerate

endmodule

// File: rtl/updown_count_field.sv
module updown_count_field #(
  parameter int WIDTH = 8,
  parameter updown_pkg::step_src_e INC_SRC = updown_pkg::STEP_INPUT,
  parameter int INC_CONST   = 1,
  parameter int INC_AMT_W   = 4,
  parameter updown_pkg::step_src_e DEC_SRC = updown_pkg::STEP_FIXED,
  parameter int DEC_CONST   = 3,
  parameter int DEC_AMT_W   = 1,
  parameter bit UP_SAT_EN   = 1'b1,
  parameter int UP_SAT_VAL  = 200,  // -1: all ones
  parameter bit DN_SAT_EN   = 1'b1,
  parameter int DN_SAT_VAL  = 5,    // -1: zero
  parameter bit HI_MARK_EN  = 1'b1,
  parameter int HI_MARK_VAL = 150,  // -1: all ones
  parameter bit LO_MARK_EN  = 1'b1,
  parameter int LO_MARK_VAL = 10,
  parameter bit HW_WINS     = 1'b0,
  parameter int RST_VAL     = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inc_pulse_i,
  input  logic [INC_AMT_W-1:0] inc_amt_i,
  input  logic                 dec_pulse_i,
  input  logic [DEC_AMT_W-1:0] dec_amt_i,
  input  logic [WIDTH-1:0]     upd_mask_i,
  input  logic                 wr_en_i,
  input  logic [WIDTH-1:0]     wr_data_i,
  output logic [WIDTH-1:0]     count_o,
  output logic                 hi_mark_o,
  output logic                 lo_mark_o,
  output logic                 over_o,
  output logic                 under_o
);

  localparam int MAXV  = (1 << WIDTH) - 1;  // WIDTH up to 30
  localparam int UP_I  = (UP_SAT_EN && UP_SAT_VAL >= 0) ? UP_SAT_VAL : MAXV;
  localparam int LO_I  = (DN_SAT_EN && DN_SAT_VAL >= 0) ? DN_SAT_VAL : 0;
  localparam int HI_I  = (HI_MARK_VAL < 0) ? MAXV : HI_MARK_VAL;
  localparam int LOM_I = (LO_MARK_VAL < 0) ? 0 : LO_MARK_VAL;
  localparam logic [WIDTH-1:0] UPPER   = WIDTH'(UP_I);
  localparam logic [WIDTH-1:0] LOWER   = WIDTH'(LO_I);
  localparam logic [WIDTH-1:0] HI_MARK = WIDTH'(HI_I);
  localparam logic [WIDTH-1:0] LO_MARK = WIDTH'(LOM_I);
  localparam logic [WIDTH-1:0] RST_CNT = WIDTH'(RST_VAL);
  localparam bit HI_RST = HI_MARK_EN && (RST_CNT >= HI_MARK);
  localparam bit LO_RST = LO_MARK_EN && (RST_CNT <= LO_MARK);

  generate
    if (INC_SRC == updown_pkg::STEP_FIXED && INC_CONST == 0 &&
        DEC_SRC == updown_pkg::STEP_FIXED && DEC_CONST == 0) begin : g_bad_cfg
      $error("updown_count_field: both step directions are forced to zero");
    end
  endgenerate

  logic             inc_act, dec_act;
  logic [WIDTH-1:0] inc_amt, dec_amt;
  logic [WIDTH-1:0] calc_res;
  logic             calc_above, calc_below;
  logic             hw_upd, sw_take, hw_take;
  logic [WIDTH-1:0] count_q, count_d, masked_res;
  logic             hi_q, hi_d, lo_q, lo_d, over_q, under_q;

  updown_step_sel #(
    .SRC(INC_SRC), .CONST_VAL(INC_CONST), .STEP_W(INC_AMT_W), .WIDTH(WIDTH)
  ) u_inc_sel (
    .strobe_i(inc_pulse_i), .step_i(inc_amt_i),
    .active_o(inc_act), .amount_o(inc_amt)
  );

  updown_step_sel #(
    .SRC(DEC_SRC), .CONST_VAL(DEC_CONST), .STEP_W(DEC_AMT_W), .WIDTH(WIDTH)
  ) u_dec_sel (
    .strobe_i(dec_pulse_i), .step_i(dec_amt_i),
    .active_o(dec_act), .amount_o(dec_amt)
  );

  updown_next_calc #(
    .WIDTH(WIDTH), .UPPER(UP_I), .LOWER(LO_I),
    .SAT_UP(UP_SAT_EN), .SAT_DN(DN_SAT_EN)
  ) u_calc (
    .cnt_i(count_q),
    .inc_act_i(inc_act), .inc_amt_i(inc_amt),
    .dec_act_i(dec_act), .dec_amt_i(dec_amt),
    .result_o(calc_res), .above_o(calc_above), .below_o(calc_below)
  );

  // Precedence between the software write and a counter update.
  assign hw_upd     = inc_act | dec_act;
  assign sw_take    = wr_en_i & (~HW_WINS | ~hw_upd);
  assign hw_take    = hw_upd & (HW_WINS | ~wr_en_i);
  assign masked_res = (calc_res & upd_mask_i) | (count_q & ~upd_mask_i);

  always_comb begin
    count_d = count_q;
    if (sw_take)      count_d = wr_data_i;
    else if (hw_take) count_d = masked_res;
  end

  generate
    if (HI_MARK_EN) begin : g_hi
      assign hi_d = count_d >= HI_MARK;
    end else begin : g_hi_off
      assign hi_d = 1'b0;
    end
    if (LO_MARK_EN) begin : g_lo
      assign lo_d = count_d <= LO_MARK;
    end else begin : g_lo_off
      assign lo_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= RST_CNT;
      hi_q    <= HI_RST;
      lo_q    <= LO_RST;
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      count_q <= count_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      over_q  <= hw_take & calc_above;
      under_q <= hw_take & calc_below;
    end
  end

  assign count_o   = count_q;
  assign hi_mark_o = hi_q;
  assign lo_mark_o = lo_q;
  assign over_o    = over_q;
  assign under_o   = under_q;

  // ---------------- assertions ----------------
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc_act && !dec_act && !wr_en_i) |=> $stable(count_q));

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(over_q && under_q));

  p_over_cause_r6: assert property (@(posedge clk) disable iff (rst)
    over_q |-> $past(hw_upd));

  p_mask_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (hw_take && !wr_en_i) |=>
      ((count_q & ~$past(upd_mask_i)) == ($past(count_q) & ~$past(upd_mask_i))));

  p_write_load_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !(HW_WINS && hw_upd)) |=> (count_q == $past(wr_data_i)));

  generate
    if (UP_SAT_EN) begin : g_chk_up
      p_upper_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (hw_take && (&upd_mask_i) && !wr_en_i) |=> (count_q <= UPPER));
    end
    if (DN_SAT_EN) begin : g_chk_dn
      p_lower_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        (hw_take && (&upd_mask_i) && !wr_en_i) |=> (count_q >= LOWER));
    end
  endgenerate

endmodule

// File: tb/updown_count_field_bench.sv
module updown_count_field_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- main instance (defaults) ----------------
  logic       m_inc = 0, m_dec = 0, m_we = 0;
  logic [3:0] m_istep = 0;
  logic [7:0] m_wd = 0, m_mask = 8'hFF;
  logic [7:0] m_cnt;
  logic       m_hi, m_lo, m_ovf, m_unf;

  updown_count_field u_updown_count_field (
    .clk(clk), .rst(rst),
    .inc_pulse_i(m_inc), .inc_amt_i(m_istep),
    .dec_pulse_i(m_dec), .dec_amt_i(1'b0),
    .upd_mask_i(m_mask), .wr_en_i(m_we), .wr_data_i(m_wd),
    .count_o(m_cnt), .hi_mark_o(m_hi), .lo_mark_o(m_lo),
    .over_o(m_ovf), .under_o(m_unf)
  );

  // ---------------- wrapping instance ----------------
  logic       w_inc = 0, w_dec = 0, w_we = 0;
  logic [3:0] w_wd = 0;
  logic [3:0] w_cnt;
  logic       w_hi, w_lo, w_ovf, w_unf;

  updown_count_field #(
    .WIDTH(4), .INC_SRC(updown_pkg::STEP_UNIT), .INC_AMT_W(1),
    .DEC_SRC(updown_pkg::STEP_UNIT), .UP_SAT_EN(1'b0), .DN_SAT_EN(1'b0),
    .HI_MARK_EN(1'b1), .HI_MARK_VAL(-1), .LO_MARK_EN(1'b0),
    .HW_WINS(1'b1), .RST_VAL(14)
  ) u_updown_count_field_wrap (
    .clk(clk), .rst(rst),
    .inc_pulse_i(w_inc), .inc_amt_i(1'b0),
    .dec_pulse_i(w_dec), .dec_amt_i(1'b0),
    .upd_mask_i(4'hF), .wr_en_i(w_we), .wr_data_i(w_wd),
    .count_o(w_cnt), .hi_mark_o(w_hi), .lo_mark_o(w_lo),
    .over_o(w_ovf), .under_o(w_unf)
  );

  // ---------------- tied-off-direction instance ----------------
  logic       t_inc = 0, t_dec = 0, t_we = 0;
  logic [3:0] t_wd = 0;
  logic [3:0] t_cnt;
  logic       t_hi, t_lo, t_ovf, t_unf;

  updown_count_field #(
    .WIDTH(4), .INC_SRC(updown_pkg::STEP_FIXED), .INC_CONST(2), .INC_AMT_W(1),
    .DEC_SRC(updown_pkg::STEP_FIXED), .DEC_CONST(0),
    .UP_SAT_EN(1'b0), .DN_SAT_EN(1'b0), .HI_MARK_EN(1'b0), .LO_MARK_EN(1'b0),
    .HW_WINS(1'b1), .RST_VAL(6)
  ) u_updown_count_field_tied (
    .clk(clk), .rst(rst),
    .inc_pulse_i(t_inc), .inc_amt_i(1'b0),
    .dec_pulse_i(t_dec), .dec_amt_i(1'b0),
    .upd_mask_i(4'hF), .wr_en_i(t_we), .wr_data_i(t_wd),
    .count_o(t_cnt), .hi_mark_o(t_hi), .lo_mark_o(t_lo),
    .over_o(t_ovf), .under_o(t_unf)
  );

  // Main instance: 8 bits, increment step from port, decrement step 3,
  // saturation 200 / 5, marks 150 / 10, software wins, reset 20.
  typedef struct packed {
    logic       inc;
    logic [3:0] istep;
    logic       dec;
    logic       we;
    logic [7:0] wd;
    logic [7:0] mask;
    logic [7:0] cnt;
    logic       ovf;
    logic       unf;
    logic       hi;
    logic       lo;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd7,  1'b0, 1'b0, 8'd0,   8'hFF, 8'd27,  1'b0, 1'b0, 1'b0, 1'b0}, // R2 inc 7
    '{1'b0, 4'd0,  1'b1, 1'b0, 8'd0,   8'hFF, 8'd24,  1'b0, 1'b0, 1'b0, 1'b0}, // R2 dec 3
    '{1'b1, 4'd15, 1'b1, 1'b0, 8'd0,   8'hFF, 8'd36,  1'b0, 1'b0, 1'b0, 1'b0}, // R2 both
    '{1'b0, 4'd0,  1'b0, 1'b1, 8'd148, 8'hFF, 8'd148, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 write
    '{1'b1, 4'd2,  1'b0, 1'b0, 8'd0,   8'hFF, 8'd150, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 hi mark
    '{1'b1, 4'd9,  1'b0, 1'b1, 8'd195, 8'hFF, 8'd195, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 sw wins
    '{1'b1, 4'd9,  1'b0, 1'b0, 8'd0,   8'hFF, 8'd200, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 clamp
    '{1'b1, 4'd0,  1'b0, 1'b0, 8'd0,   8'hFF, 8'd200, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 at limit
    '{1'b0, 4'd0,  1'b0, 1'b1, 8'd8,   8'hFF, 8'd8,   1'b0, 1'b0, 1'b0, 1'b1}, // R7 lo mark
    '{1'b0, 4'd0,  1'b1, 1'b0, 8'd0,   8'hFF, 8'd5,   1'b0, 1'b0, 1'b0, 1'b1}, // R4 onto limit
    '{1'b0, 4'd0,  1'b1, 1'b0, 8'd0,   8'hFF, 8'd5,   1'b0, 1'b1, 1'b0, 1'b1}, // R6 underflow
    '{1'b1, 4'd15, 1'b0, 1'b0, 8'd0,   8'h0F, 8'd4,   1'b0, 1'b0, 1'b0, 1'b1}, // R8 mask
    '{1'b0, 4'd0,  1'b0, 1'b0, 8'd0,   8'hFF, 8'd4,   1'b0, 1'b0, 1'b0, 1'b1}  // R2 idle
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R2", "R9", "R7", "R9", "R3",
                                  "R6", "R7", "R4", "R6", "R8", "R2"};

  task automatic w_cycle(input logic inc, input logic dec, input logic we, input logic [3:0] wd);
    @(negedge clk);
    w_inc = inc; w_dec = dec; w_we = we; w_wd = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic t_cycle(input logic inc, input logic dec, input logic we, input logic [3:0] wd);
    @(negedge clk);
    t_inc = inc; t_dec = dec; t_we = we; t_wd = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic w_expect(input string req, input int cnt, input int hi, input int ovf, input int unf);
    check(req, "wrap count", int'(w_cnt), cnt);
    check(req, "wrap hi", int'(w_hi), hi);
    check(req, "wrap over", int'(w_ovf), ovf);
    check(req, "wrap under", int'(w_unf), unf);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state of every instance
    check("R1", "count", int'(m_cnt), 20);
    check("R1", "hi", int'(m_hi), 0);
    check("R1", "lo", int'(m_lo), 0);
    check("R1", "over", int'(m_ovf), 0);
    check("R1", "under", int'(m_unf), 0);
    check("R1", "wrap count", int'(w_cnt), 14);
    check("R1", "tied count", int'(t_cnt), 6);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      m_inc = VECS[i].inc; m_istep = VECS[i].istep; m_dec = VECS[i].dec;
      m_we = VECS[i].we; m_wd = VECS[i].wd; m_mask = VECS[i].mask;
      @(posedge clk);
      #1;
      check(TAGS[i], $sformatf("row %0d count", i), int'(m_cnt), int'(VECS[i].cnt));
      check(TAGS[i], $sformatf("row %0d over", i), int'(m_ovf), int'(VECS[i].ovf));
      check(TAGS[i], $sformatf("row %0d under", i), int'(m_unf), int'(VECS[i].unf));
      check(TAGS[i], $sformatf("row %0d hi", i), int'(m_hi), int'(VECS[i].hi));
      check(TAGS[i], $sformatf("row %0d lo", i), int'(m_lo), int'(VECS[i].lo));
    end
    @(negedge clk);
    m_inc = 0; m_dec = 0; m_we = 0; m_mask = 8'hFF;

    // Wrapping instance: 4 bits, unit steps, high mark all ones, hardware wins
    w_cycle(1, 0, 0, 0); w_expect("R7", 15, 1, 0, 0);
    w_cycle(1, 0, 0, 0); w_expect("R5", 0, 0, 1, 0);   // wraps up, overflow
    w_cycle(0, 1, 0, 0); w_expect("R5", 15, 1, 0, 1);  // wraps down, underflow
    w_cycle(1, 0, 1, 3); w_expect("R9", 0, 0, 1, 0);   // update beats write
    w_cycle(0, 0, 1, 3); w_expect("R9", 3, 0, 0, 0);
    w_cycle(1, 1, 0, 0); w_expect("R2", 3, 0, 0, 0);   // net zero
    w_cycle(0, 0, 0, 0);
    check("R7", "wrap lo disabled", int'(w_lo), 0);

    // Tied-off decrement: fixed step 0
    t_cycle(0, 1, 0, 0);
    check("R10", "tied dec alone", int'(t_cnt), 6);
    check("R10", "tied dec no pulse", int'(t_unf), 0);
    t_cycle(0, 1, 1, 9);
    check("R10", "tied dec with write", int'(t_cnt), 9);
    t_cycle(1, 0, 0, 0);
    check("R2", "tied fixed inc 2", int'(t_cnt), 11);
    t_cycle(1, 0, 1, 1);
    check("R9", "tied update beats write", int'(t_cnt), 13);
    t_cycle(0, 0, 0, 0);
    check("R2", "tied idle", int'(t_cnt), 13);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule